// File: doc/BRIEF.md
# Immediate-Amount Shift Unit

This unit performs the logical and arithmetic shifts whose shift distance is a constant held in the instruction word. It sits beside the main arithmetic unit in a single-cycle datapath. It receives the register operand that is to be shifted and the full 32-bit instruction. From the instruction it takes the shift distance and the shift kind, and it produces the shifted word with no clock involved.

The unit also decodes the instruction itself and raises a select flag when the instruction is one of the three register-format shifts. The write-back multiplexer uses this flag to route the shifter result in place of the arithmetic result. Shifts by a distance taken from a register are not handled here, and neither are rotates.

Top module: `imm_shift_unit`

## Requirements
- R1: The shift distance is the unsigned 5-bit field at instruction bits 10 down to 6.
- R2: When instruction bits 1:0 are 00, the result is the operand shifted toward the MSB by the distance, with zeros entering at the LSB end (7 shifted by 10 gives 7168).
- R3: When instruction bits 1:0 are 10, the result is the operand shifted toward the LSB by the distance, with zeros entering at the MSB end (7424 shifted by 6 gives 116).
- R4: When instruction bits 1:0 are 11, the result is the operand shifted toward the LSB by the distance, with every vacated upper bit equal to operand bit 31 (-1280 shifted by 7 gives -10).
- R5: When instruction bits 1:0 are 01, the result equals the operand unchanged.
- R6: A distance of 0 yields the operand unchanged in every mode.
- R7: The select flag is 1 exactly when instruction bits 31:26 are all zero and bits 5:0 are 000000, 000010 or 000011; it is 0 for every other instruction, including funct 000001.
- R8: The shifted result depends only on the operand and on instruction bits 10:6 and 1:0; the opcode, register fields and funct bits 5:2 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_opnd | input | 32 | Register operand to be shifted |
| instr_word | input | 32 | Current instruction word |
| shift_res | output | 32 | Shifted operand |
| take_shift | output | 1 | Select flag for the write-back multiplexer: 1 picks the shifter result |

## Verification
The worked examples check each direction against values known in advance. A distance of 0 and a distance of 31 on operands with a set sign bit separate zero fill from sign fill and expose stage wiring faults at both ends of the range. Instructions that hold the shift fields fixed but scramble the opcode, register fields and upper funct bits show that the result ignores those bits and that the flag follows only opcode and funct. Thousands of random operand and instruction pairs, biased so that about half carry a zero opcode, are compared against reference functions built on the language shift operators.

// File: rtl/imm_shift_unit.sv
module imm_shift_unit #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] src_opnd,
  input  logic [31:0]   instr_word,
  output logic [DW-1:0] shift_res,
  output logic          take_shift
);
  localparam int SHW = 5;
  localparam int NSTG = (SHW < $clog2(DW)) ? SHW : $clog2(DW);

  logic [SHW-1:0] amt;
  logic [1:0]     mode;
  logic [5:0]     opc, fn;
  logic           go_left, go_arith, pass;
  logic           fill;
  logic [DW-1:0]  rev_in, pre, post_rev;
  logic [DW-1:0]  stg [0:NSTG];

  assign amt      = instr_word[10:6];
  assign mode     = instr_word[1:0];
  assign opc      = instr_word[31:26];
  assign fn       = instr_word[5:0];
  assign go_left  = (mode == 2'b00);
  assign go_arith = (mode == 2'b11);
  assign pass     = (mode == 2'b01);
  assign fill     = go_arith & src_opnd[DW-1];

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_rev
      assign rev_in[i]   = src_opnd[DW-1-i];
      assign post_rev[i] = stg[NSTG][DW-1-i];
    end
  endgenerate

  assign pre    = go_left ? rev_in : src_opnd;
  assign stg[0] = pre;

  genvar k;
  generate
    for (k = 0; k < NSTG; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][DW-1:D]} : stg[k];
    end
  endgenerate

  assign shift_res  = pass ? src_opnd : (go_left ? post_rev : stg[NSTG]);
  assign take_shift = (opc == 6'd0) && (fn == 6'b000000 || fn == 6'b000010 || fn == 6'b000011);

  always_comb begin
    if (!$isunknown({src_opnd, instr_word})) begin
      // R7
      flag_needs_zero_op_chk: assert (!take_shift || opc == 6'd0);
      // R7
      flag_not_on_mode01_chk: assert (!(take_shift && mode == 2'b01));
      // R6
      zero_amt_pass_chk: assert (amt != '0 || shift_res == src_opnd);
      // R5
      mode01_pass_chk: assert (!pass || shift_res == src_opnd);
      // R4
      arith_fill_chk: assert (!(go_arith && amt != '0) || shift_res[DW-1] == src_opnd[DW-1]);
      // R3
      logic_right_fill_chk: assert (!(mode == 2'b10 && amt != '0) || shift_res[DW-1] == 1'b0);
      // R2
      left_fill_chk: assert (!(go_left && amt != '0) || shift_res[0] == 1'b0);
    end
  end
endmodule

// File: tb/imm_shift_unit_tb.sv
module imm_shift_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] src_opnd, instr_word, shift_res;
  logic        take_shift;
  int total = 0, bad = 0;
  bit done = 0;

  imm_shift_unit u_dut (
    .src_opnd(src_opnd), .instr_word(instr_word),
    .shift_res(shift_res), .take_shift(take_shift)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] ins);
    int s = int'(ins[10:6]);
    case (ins[1:0])
      2'b00:   return a << s;
      2'b10:   return a >> s;
      2'b11:   return $unsigned($signed(a) >>> s);
      default: return a;
    endcase
  endfunction

  function automatic logic ref_flag(input logic [31:0] ins);
    return ins[31:26] == 6'd0 && (ins[5:0] == 6'd0 || ins[5:0] == 6'd2 || ins[5:0] == 6'd3);
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] sh, input logic [5:0] fn);
    return {op, 5'd0, 5'd2, 5'd8, sh, fn};
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] ins);
    logic [31:0] er; logic ef;
    @(posedge clk);
    src_opnd = a; instr_word = ins;
    @(negedge clk);
    er = ref_res(a, ins); ef = ref_flag(ins);
    total++;
    if (shift_res !== er || take_shift !== ef) begin
      bad++;
      $display("FAIL %s: a=%h ins=%h res=%h exp=%h flag=%b exp=%b", tag, a, ins, shift_res, er, take_shift, ef);
    end
  endtask

  task automatic chk_val(input string tag, input logic [31:0] a, input logic [31:0] ins, input logic [31:0] ev);
    @(posedge clk);
    src_opnd = a; instr_word = ins;
    @(negedge clk);
    total++;
    if (shift_res !== ev) begin
      bad++;
      $display("FAIL %s: res=%h exp=%h", tag, shift_res, ev);
    end
  endtask

  initial begin
    src_opnd = 0; instr_word = 0;
    @(negedge clk);
    total++;
    if (shift_res !== 32'd0 || take_shift !== 1'b1) begin
      bad++;
      $display("FAIL R7 reset-state: res=%h exp=0 flag=%b exp=1", shift_res, take_shift);
    end
    // worked examples: R1 R2 R3 R4
    chk_val("R2", 32'd7, mk(6'd0, 5'd10, 6'b000000), 32'd7168);
    chk_val("R3", 32'd7424, mk(6'd0, 5'd6, 6'b000010), 32'd116);
    chk_val("R4", 32'hFFFFFB00, mk(6'd0, 5'd7, 6'b000011), 32'hFFFFFFF6);
    chk_val("R1", 32'h8000_0000, mk(6'd0, 5'd31, 6'b000010), 32'd1);
    chk_val("R4", 32'h8000_0000, mk(6'd0, 5'd31, 6'b000011), 32'hFFFFFFFF);
    chk_val("R2", 32'hFFFF_FFFF, mk(6'd0, 5'd31, 6'b000000), 32'h8000_0000);
    // R5 mode 01
    chk_val("R5", 32'hDEAD_BEEF, mk(6'd0, 5'd9, 6'b000001), 32'hDEAD_BEEF);
    chk("R7", 32'h1234_5678, mk(6'd0, 5'd9, 6'b000001));
    // R6 zero distance in all modes
    for (int m = 0; m < 4; m++)
      chk_val("R6", 32'h9ABC_DEF0, mk(6'd0, 5'd0, {4'd0, 2'(m)}), 32'h9ABC_DEF0);
    // R7 non-zero opcode, other funct
    chk("R7", 32'h0F0F_0F0F, mk(6'b100011, 5'd4, 6'b000000));
    chk("R7", 32'h0F0F_0F0F, mk(6'd0, 5'd4, 6'b100000));
    chk("R7", 32'h0F0F_0F0F, mk(6'd0, 5'd4, 6'b000110));
    // R8 other bits ignored by the result
    for (int j = 0; j < 8; j++) begin
      logic [31:0] ins = $urandom;
      ins[10:6] = 5'd13; ins[1:0] = 2'b11;
      chk_val("R8", 32'hC000_0001, ins, 32'hFFFE_0000);
    end
    // random
    void'($urandom(32'd4242));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a = $urandom, ins = $urandom;
      if ($urandom_range(1, 0) == 1) ins[31:26] = 6'd0;
      if ($urandom_range(1, 0) == 1) ins[5:2] = 4'd0;
      chk("R8 random", a, ins);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule